// File: doc/BRIEF.md
# Pixel Output Mask Stage

This block is the last stage of a video pixel pipeline. On every pixel clock it takes a background pixel, a sprite pixel with its priority flag, the horizontal pixel position and the current mask control byte. From these it produces one palette entry index and three colour-emphasis bits. Each layer can be switched off on its own and can be hidden in the leftmost eight columns on its own. The layer-select multiplexer picks the visible pixel. An optional grayscale mode then keeps only the top two bits of the chosen index, and the emphasis bits go out next to it unchanged.

A pixel input is 4 bits: bits [3:2] are a palette group and bits [1:0] are a colour number. Colour number 0 means transparent. Both outputs are registered, so the result for the inputs sampled at one clock edge appears after that edge. Palette memory and the conversion to an analog level are handled further downstream.

Top module: `pixel_mask_stage`

## Requirements
- R1: The outputs present the result for the inputs sampled at the previous rising clock edge, which gives one cycle of latency.
- R2: While rstN is low, colourOut is 6'h00 and emphOut is 3'b000.
- R3: maskIn bit 3 enables the background. When it is 0, the background pixel is treated as transparent.
- R4: maskIn bit 4 enables sprites. When it is 0, the sprite pixel is treated as transparent.
- R5: When xPos is below 8 and maskIn bit 1 is 0, the background pixel is transparent. When maskIn bit 1 is 1, the background is shown in those columns.
- R6: When xPos is below 8 and maskIn bit 2 is 0, the sprite pixel is transparent. This works independently of maskIn bit 1.
- R7: A pixel whose bits [1:0] are 00 is transparent. When both layers are transparent, colourOut is the backdrop entry 6'h00.
- R8: An opaque sprite with sprBehind=0 wins over the background. With sprBehind=1, an opaque background wins. A sprite gives colourOut={2'b01,sprPix} and a background gives colourOut={2'b00,bgPix}.
- R9: When maskIn bit 0 is 1, the selected index is ANDed with 6'h30 before it is registered.
- R10: emphOut equals maskIn[7:5] ({blue,green,red}) whatever the grayscale setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low reset |
| bgPix | input | 4 | Background pixel: group [3:2], colour [1:0] |
| sprPix | input | 4 | Sprite pixel: group [3:2], colour [1:0] |
| sprBehind | input | 1 | Sprite priority: 1 puts the sprite behind the background |
| xPos | input | 8 | Horizontal pixel position |
| maskIn | input | 8 | Mask control byte |
| colourOut | output | 6 | Registered palette entry index |
| emphOut | output | 3 | Registered emphasis bits {blue,green,red} |

## Verification
The bench steps xPos across the edge between column 7 and column 8 with each clip bit set on its own. A design that shares one clip control between the layers, or that clips at the wrong column, shows the wrong layer at x=7 or x=8. It sets up sprite and background collisions with both priority values and with transparent colour numbers, which catches a reversed priority or a design that treats a transparent sprite as a winner. It also turns on grayscale while emphasis bits are set. This exposes masking applied to the raw pixel rather than the selected index, and emphasis bits that are cleared when grayscale is on.

// File: rtl/pixel_mask_pkg.sv
package pixel_mask_pkg;
  parameter int PIX_W   = 4;
  parameter int COL_W   = 2;
  parameter int OUT_W   = 6;
  parameter int EMPH_W  = 3;
  parameter int X_W     = 8;
  parameter int CLIP_COLS = 8;
  parameter logic [OUT_W-1:0] GRAY_KEEP = 6'h30;

  typedef struct packed {
    logic bgShow;
    logic sprShow;
    logic gray;
    logic [EMPH_W-1:0] emph;
  } strobe_t;
endpackage

// File: rtl/pixel_mask_ctrl.sv
module pixel_mask_ctrl
  import pixel_mask_pkg::*;
(
  input  logic [X_W-1:0] xPos,
  input  logic [7:0]     maskIn,
  output strobe_t        strobes
);
  logic inLeftEdge;

  always_comb begin
    inLeftEdge       = (xPos < X_W'(CLIP_COLS));
    strobes.bgShow   = maskIn[3] & (maskIn[1] | ~inLeftEdge);
    strobes.sprShow  = maskIn[4] & (maskIn[2] | ~inLeftEdge);
    strobes.gray     = maskIn[0];
    strobes.emph     = maskIn[7:5];
  end
endmodule

// File: rtl/pixel_mask_datapath.sv
module pixel_mask_datapath
  import pixel_mask_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PIX_W-1:0]  bgPix,
  input  logic [PIX_W-1:0]  sprPix,
  input  logic              sprBehind,
  input  strobe_t           strobes,
  output logic [OUT_W-1:0]  colourOut,
  output logic [EMPH_W-1:0] emphOut
);
  localparam int PAD_W = OUT_W - PIX_W - 1;

  logic bgOpaque;
  logic sprOpaque;
  logic [OUT_W-1:0] selIndex;
  logic [OUT_W-1:0] maskedIndex;

  always_comb begin
    bgOpaque  = strobes.bgShow  & (bgPix[COL_W-1:0]  != '0);
    sprOpaque = strobes.sprShow & (sprPix[COL_W-1:0] != '0);
    if (sprOpaque && (!sprBehind || !bgOpaque))
      selIndex = {{PAD_W{1'b0}}, 1'b1, sprPix};
    else if (bgOpaque)
      selIndex = {{PAD_W{1'b0}}, 1'b0, bgPix};
    else
      selIndex = '0;
    maskedIndex = strobes.gray ? (selIndex & GRAY_KEEP) : selIndex;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colourOut <= '0;
      emphOut   <= '0;
    end else begin
      colourOut <= maskedIndex;
      emphOut   <= strobes.emph;
    end
  end
endmodule

// File: rtl/pixel_mask_stage.sv
module pixel_mask_stage
  import pixel_mask_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  bgPix,
  input  logic [3:0]  sprPix,
  input  logic        sprBehind,
  input  logic [7:0]  xPos,
  input  logic [7:0]  maskIn,
  output logic [5:0]  colourOut,
  output logic [2:0]  emphOut
);
  strobe_t strobes;

  pixel_mask_ctrl u_ctrl (
    .xPos    (xPos),
    .maskIn  (maskIn),
    .strobes (strobes)
  );

  pixel_mask_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .bgPix     (bgPix),
    .sprPix    (sprPix),
    .sprBehind (sprBehind),
    .strobes   (strobes),
    .colourOut (colourOut),
    .emphOut   (emphOut)
  );
endmodule

// File: rtl/pixel_mask_checker.sv
module pixel_mask_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] bgPix,
  input logic [3:0] sprPix,
  input logic [7:0] xPos,
  input logic [7:0] maskIn,
  input logic [5:0] colourOut,
  input logic [2:0] emphOut
);
  // R3/R4: both layers off gives the backdrop
  a_r3_layers_off: assert property (@(posedge clk) disable iff (!rstN)
    (!maskIn[3] && !maskIn[4]) |=> (colourOut == 6'h00));

  // R5: background clipped at the left edge with sprites off
  a_r5_bg_clip: assert property (@(posedge clk) disable iff (!rstN)
    (xPos < 8'd8 && !maskIn[1] && !maskIn[4]) |=> (colourOut == 6'h00));

  // R7: both pixels transparent gives the backdrop
  a_r7_backdrop: assert property (@(posedge clk) disable iff (!rstN)
    (bgPix[1:0] == 2'b00 && sprPix[1:0] == 2'b00) |=> (colourOut == 6'h00));

  // R9: grayscale leaves only bits 5:4
  a_r9_gray: assert property (@(posedge clk) disable iff (!rstN)
    maskIn[0] |=> (colourOut[3:0] == 4'h0));

  // R10: emphasis follows the mask one cycle later
  a_r10_emph: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (emphOut == $past(maskIn[7:5])));
endmodule

bind pixel_mask_stage pixel_mask_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bgPix     (bgPix),
  .sprPix    (sprPix),
  .xPos      (xPos),
  .maskIn    (maskIn),
  .colourOut (colourOut),
  .emphOut   (emphOut)
);

// File: tb/pixel_mask_stage_tb.sv
`timescale 1ns/1ps
module pixel_mask_stage_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] bgPix = '0;
  logic [3:0] sprPix = '0;
  logic       sprBehind = 1'b0;
  logic [7:0] xPos = '0;
  logic [7:0] maskIn = '0;
  logic [5:0] colourOut;
  logic [2:0] emphOut;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pixel_mask_stage u_dut (
    .clk(clk), .rstN(rstN), .bgPix(bgPix), .sprPix(sprPix),
    .sprBehind(sprBehind), .xPos(xPos), .maskIn(maskIn),
    .colourOut(colourOut), .emphOut(emphOut)
  );

  // behavioural reference
  function automatic logic [8:0] refModel(input logic [3:0] b, input logic [3:0] s,
                                          input logic pri, input int x, input logic [7:0] m);
    int idx;
    bit bVis, sVis;
    bVis = m[3] && (m[1] || x >= 8) && (b % 4 != 0);
    sVis = m[4] && (m[2] || x >= 8) && (s % 4 != 0);
    if (sVis && (!pri || !bVis)) idx = 16 + s;
    else if (bVis) idx = b;
    else idx = 0;
    if (m[0]) idx = idx & 48;
    return {m[7:5], 6'(idx)};
  endfunction

  task automatic check(input string tag, input logic [8:0] exp);
    vectors++;
    if ({emphOut, colourOut} !== exp) begin
      miscompares++;
      $display("FAIL %s: got emph=%b colour=%h, expected emph=%b colour=%h",
               tag, emphOut, colourOut, exp[8:6], exp[5:0]);
    end
  endtask

  // drive at negedge, compare at the following negedge (one register)
  task automatic apply(input string tag, input logic [3:0] b, input logic [3:0] s,
                       input logic pri, input int x, input logic [7:0] m);
    logic [8:0] exp;
    bgPix = b; sprPix = s; sprBehind = pri; xPos = 8'(x); maskIn = m;
    exp = refModel(b, s, pri, x, m);
    @(posedge clk);
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    maskIn = 8'hFF; bgPix = 4'h7; sprPix = 4'h5;
    repeat (3) @(negedge clk);
    check("R2 reset", 9'h000);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R3 / R4 enables
    apply("R1 latency bg", 4'h6, 4'h0, 1'b0, 20, 8'h08);
    apply("R3 bg off", 4'h6, 4'h0, 1'b0, 20, 8'h10);
    apply("R4 spr off", 4'h0, 4'h9, 1'b0, 20, 8'h08);
    apply("R4 spr on", 4'h0, 4'h9, 1'b0, 20, 8'h10);
    // R5 / R6 clip boundaries
    for (int x = 6; x <= 9; x++) begin
      apply("R5 bg clip", 4'hB, 4'h0, 1'b0, x, 8'h18);
      apply("R5 bg show", 4'hB, 4'h0, 1'b0, x, 8'h1A);
      apply("R6 spr clip", 4'h2, 4'hD, 1'b0, x, 8'h1A);
      apply("R6 spr show", 4'h2, 4'hD, 1'b0, x, 8'h1C);
    end
    // R7 transparency
    apply("R7 backdrop", 4'hC, 4'h8, 1'b0, 50, 8'h1E);
    apply("R7 spr transparent", 4'h3, 4'h4, 1'b0, 50, 8'h1E);
    // R8 priority
    apply("R8 spr front", 4'h1, 4'hE, 1'b0, 50, 8'h1E);
    apply("R8 spr behind", 4'h1, 4'hE, 1'b1, 50, 8'h1E);
    apply("R8 behind over clear bg", 4'h0, 4'hE, 1'b1, 50, 8'h1E);
    // R9 / R10 grayscale and emphasis
    apply("R9 gray spr", 4'h1, 4'hF, 1'b0, 50, 8'hFF);
    apply("R9 gray bg", 4'hF, 4'h0, 1'b0, 50, 8'h0B);
    apply("R10 emph with gray", 4'h0, 4'h0, 1'b0, 50, 8'hA1);
    apply("R10 emph", 4'h5, 4'h0, 1'b0, 50, 8'h48);

    // mixed stream
    for (int i = 0; i < 400; i++)
      apply("R8 R9 mixed", 4'($urandom), 4'($urandom), 1'($urandom),
            int'($urandom_range(0, 15)), 8'($urandom));

    // R2 reset mid-run
    rstN = 1'b0;
    #1;
    check("R2 async reset", 9'h000);
    @(negedge clk);
    rstN = 1'b1;
    apply("R1 after reset", 4'h5, 4'h0, 1'b0, 30, 8'h08);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule